// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Unit

This block sits beside a dual-clock FIFO and decides when the FIFO is close to either boundary. It keeps two 14-bit threshold registers. One sets the distance from empty and the other the distance from full. Both are loaded through the FIFO's own data input and read back through a dedicated read-back output. This access happens only while a shared active-low load strobe is held low.

A single load strobe serves both registers. Each enabled write edge toggles a write-side selector, and each enabled read edge toggles a separate read-side selector. Offsets are therefore visited empty first, then full, then empty again. Leaving load mode does not rewind either selector.

The two active-low flags compare the FIFO word counts against the thresholds. A mode pin chooses how they are produced:
- In clocked mode, the almost-empty flag is a register on the read clock and the almost-full flag is a register on the write clock.
- In combinational mode, both flags follow the counts directly.

While load is low, the block also blocks the FIFO push and pop strobes it passes on.

Top module: `aflag_unit`

## Requirements
- R1: A synchronous active-high reset sets both thresholds to 127 and points both selectors at the empty threshold. It also clears the read-back output to 0, drives the clocked almost-empty flag low and drives the clocked almost-full flag high.
- R2: With `load_n`=0 and `wr_en_n`=0, each rising write-clock edge stores `wr_data[13:0]` into the selected threshold. The first such edge stores the empty threshold, the next stores the full threshold, and so on alternating.
- R3: Raising `load_n` between loads keeps the write selector where it was, so a later load continues with the other threshold.
- R4: With `load_n`=0 and `rd_en_n`=0, each rising read-clock edge copies the selected threshold, zero-extended, to `rd_data` and toggles the read selector. The order is empty then full. `rd_data` holds its value otherwise.
- R5: The almost-empty condition is true when the read-side count is less than or equal to the empty threshold; `ae_n` is low when the condition holds.
- R6: The almost-full condition is true when the write-side count plus the full threshold is at least DEPTH (16384); `af_n` is low when the condition holds.
- R7: With `sync_mode`=1, `ae_n` shows the condition sampled at the previous read-clock edge and `af_n` shows the condition sampled at the previous write-clock edge.
- R8: With `sync_mode`=0, both flags follow the current counts and thresholds in the same cycle.
- R9: `push` is 1 only when `load_n`=1 and `wr_en_n`=0. `pop` is 1 only when `load_n`=1 and `rd_en_n`=0.
- R10: While `load_n`=1, the enables have no effect on the thresholds, on either selector or on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst | input | 1 | Synchronous active-high reset, sampled in each domain |
| sync_mode | input | 1 | 1 = clocked flags, 0 = combinational flags |
| load_n | input | 1 | Active-low threshold access strobe |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| wr_data | input | 18 | FIFO input word; low 14 bits carry a threshold |
| wr_count | input | 15 | Word count as seen in the write domain |
| rd_count | input | 15 | Word count as seen in the read domain |
| rd_data | output | 18 | Threshold read-back word |
| ae_n | output | 1 | Active-low almost-empty flag |
| af_n | output | 1 | Active-low almost-full flag |
| push | output | 1 | Gated FIFO write strobe |
| pop | output | 1 | Gated FIFO read strobe |

## Verification
Results fall due at different times:

| Result | When it is due |
|---|---|
| Threshold stores and `rd_data` | One clock edge after the enabling stimulus |
| Clocked flags | One edge after the count or threshold they reflect |
| Combinational flags, `push` and `pop` | In the same cycle as their inputs |

The bench applies inputs 1 ns after each rising edge. Its behavioural model advances on the rising edge using only pre-edge values. Every output is compared at the falling edge, which is where both the registered and the combinational results for that cycle are settled. Threshold stores have no port of their own, so they are observed later through the read-back path.

// File: rtl/aflag_pkg.sv
package aflag_pkg;
    parameter int DATA_W = 18;
    parameter int OFS_W  = 14;
    parameter int DEPTH  = 16384;
    parameter int OFS_DEFAULT = 127;

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SUM_W = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 1;

    typedef logic [OFS_W-1:0] ofs_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    typedef struct packed {
        ofs_t empty_ofs;
        ofs_t full_ofs;
    } ofs_pair_t;

    function automatic ofs_sel_e sel_next(input ofs_sel_e s);
        return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction

    function automatic ofs_t pick_ofs(input ofs_pair_t p, input ofs_sel_e s);
        return (s == SEL_EMPTY) ? p.empty_ofs : p.full_ofs;
    endfunction

    // true when the count is within the empty-side distance
    function automatic logic near_empty(input cnt_t count, input ofs_t ofs);
        logic [SUM_W-1:0] c;
        logic [SUM_W-1:0] o;
        c = SUM_W'(count);
        o = SUM_W'(ofs);
        return c <= o;
    endfunction

    // true when the count is within the full-side distance
    function automatic logic near_full(input cnt_t count, input ofs_t ofs);
        logic [SUM_W-1:0] s;
        s = SUM_W'(count) + SUM_W'(ofs);
        return s >= SUM_W'(DEPTH);
    endfunction
endpackage

// File: rtl/aflag_ofs_store.sv
module aflag_ofs_store
    import aflag_pkg::*;
(
    input  logic              wr_clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    output ofs_pair_t         ofs,
    output ofs_sel_e          wsel
);
    logic ld_wr;
    assign ld_wr = !load_n && !wr_en_n;

    always_ff @(posedge wr_clk) begin
        if (rst) begin
            ofs.empty_ofs <= ofs_t'(OFS_DEFAULT);
            ofs.full_ofs  <= ofs_t'(OFS_DEFAULT);
            wsel          <= SEL_EMPTY;
        end else if (ld_wr) begin
            if (wsel == SEL_EMPTY) ofs.empty_ofs <= wr_data[OFS_W-1:0];
            else                   ofs.full_ofs  <= wr_data[OFS_W-1:0];
            wsel <= sel_next(wsel);
        end
    end
endmodule

// File: rtl/aflag_readback.sv
module aflag_readback
    import aflag_pkg::*;
(
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic              rd_en_n,
    input  ofs_pair_t         ofs,
    output logic [DATA_W-1:0] rd_data,
    output ofs_sel_e          rsel
);
    logic ld_rd;
    assign ld_rd = !load_n && !rd_en_n;

    always_ff @(posedge rd_clk) begin
        if (rst) begin
            rd_data <= '0;
            rsel    <= SEL_EMPTY;
        end else if (ld_rd) begin
            rd_data <= DATA_W'(pick_ofs(ofs, rsel));
            rsel    <= sel_next(rsel);
        end
    end
endmodule

// File: rtl/aflag_edge_flag.sv
module aflag_edge_flag
    import aflag_pkg::*;
#(
    parameter bit FULL_SIDE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_mode,
    input  cnt_t count,
    input  ofs_t ofs,
    output logic flag_n
);
    logic hit;
    logic flag_q;

    generate
        if (FULL_SIDE) begin : g_full
            assign hit = near_full(count, ofs);
        end else begin : g_empty
            assign hit = near_empty(count, ofs);
        end
    endgenerate

    // reset value: almost-empty asserted, almost-full released
    always_ff @(posedge clk) begin
        if (rst) flag_q <= FULL_SIDE;
        else     flag_q <= !hit;
    end

    assign flag_n = sync_mode ? flag_q : !hit;
endmodule

// File: rtl/aflag_unit.sv
module aflag_unit
    import aflag_pkg::*;
(
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              sync_mode,
    input  logic              load_n,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  wr_count,
    input  logic [CNT_W-1:0]  rd_count,
    output logic [DATA_W-1:0] rd_data,
    output logic              ae_n,
    output logic              af_n,
    output logic              push,
    output logic              pop
);
    ofs_pair_t ofs;
    ofs_sel_e  wsel;
    ofs_sel_e  rsel;

    aflag_ofs_store i_store (
        .wr_clk (wr_clk),
        .rst    (rst),
        .load_n (load_n),
        .wr_en_n(wr_en_n),
        .wr_data(wr_data),
        .ofs    (ofs),
        .wsel   (wsel)
    );

    aflag_readback i_readback (
        .rd_clk (rd_clk),
        .rst    (rst),
        .load_n (load_n),
        .rd_en_n(rd_en_n),
        .ofs    (ofs),
        .rd_data(rd_data),
        .rsel   (rsel)
    );

    aflag_edge_flag #(.FULL_SIDE(1'b0)) i_ae (
        .clk      (rd_clk),
        .rst      (rst),
        .sync_mode(sync_mode),
        .count    (rd_count),
        .ofs      (ofs.empty_ofs),
        .flag_n   (ae_n)
    );

    aflag_edge_flag #(.FULL_SIDE(1'b1)) i_af (
        .clk      (wr_clk),
        .rst      (rst),
        .sync_mode(sync_mode),
        .count    (wr_count),
        .ofs      (ofs.full_ofs),
        .flag_n   (af_n)
    );

    // threshold access steals the enables from the FIFO
    assign push = load_n && !wr_en_n;
    assign pop  = load_n && !rd_en_n;
endmodule

// File: rtl/aflag_unit_chk.sv
module aflag_unit_chk
    import aflag_pkg::*;
(
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst,
    input logic              sync_mode,
    input logic              load_n,
    input logic              wr_en_n,
    input logic              rd_en_n,
    input logic [CNT_W-1:0]  wr_count,
    input logic [CNT_W-1:0]  rd_count,
    input logic [DATA_W-1:0] rd_data,
    input logic              ae_n,
    input logic              af_n,
    input logic              push,
    input logic              pop,
    input ofs_pair_t         ofs,
    input ofs_sel_e          wsel,
    input ofs_sel_e          rsel
);
    p_reset_defaults_r1: assert property (@(posedge wr_clk)
        rst |=> (ofs.empty_ofs == ofs_t'(OFS_DEFAULT) && ofs.full_ofs == ofs_t'(OFS_DEFAULT)
                 && wsel == SEL_EMPTY));

    p_wsel_toggle_r2: assert property (@(posedge wr_clk) disable iff (rst)
        (!load_n && !wr_en_n) |=> (wsel != $past(wsel)));

    p_wsel_hold_r3: assert property (@(posedge wr_clk) disable iff (rst)
        load_n |=> ($stable(wsel) && $stable(ofs)));

    p_readback_r4: assert property (@(posedge rd_clk) disable iff (rst)
        (!load_n && !rd_en_n) |=>
            (rd_data == DATA_W'($past(rsel == SEL_EMPTY ? ofs.empty_ofs : ofs.full_ofs))));

    p_readback_hold_r10: assert property (@(posedge rd_clk) disable iff (rst)
        load_n |=> ($stable(rd_data) && $stable(rsel)));

    p_ae_clocked_r7: assert property (@(posedge rd_clk) disable iff (rst)
        1'b1 |=> (!sync_mode || ae_n == !$past(rd_count <= CNT_W'(ofs.empty_ofs))));

    always_comb begin
        if (!sync_mode) begin
            p_af_comb_r8: assert ((32'(wr_count) + 32'(ofs.full_ofs) >= 32'(DEPTH)) == !af_n);
        end
        if (!load_n) begin
            p_gate_r9: assert (!push && !pop);
        end
    end
endmodule

bind aflag_unit aflag_unit_chk i_aflag_unit_chk (
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .rst      (rst),
    .sync_mode(sync_mode),
    .load_n   (load_n),
    .wr_en_n  (wr_en_n),
    .rd_en_n  (rd_en_n),
    .wr_count (wr_count),
    .rd_count (rd_count),
    .rd_data  (rd_data),
    .ae_n     (ae_n),
    .af_n     (af_n),
    .push     (push),
    .pop      (pop),
    .ofs      (ofs),
    .wsel     (wsel),
    .rsel     (rsel)
);

// File: tb/test_aflag_unit.sv
`timescale 1ns/1ps
module test_aflag_unit;
    import aflag_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst = 1'b1;
    logic              sync_mode = 1'b1;
    logic              load_n = 1'b1;
    logic              wr_en_n = 1'b1;
    logic              rd_en_n = 1'b1;
    logic [DATA_W-1:0] wr_data = '0;
    logic [CNT_W-1:0]  wr_count = '0;
    logic [CNT_W-1:0]  rd_count = '0;
    logic [DATA_W-1:0] rd_data;
    logic              ae_n, af_n, push, pop;

    aflag_unit i_aflag_unit (
        .wr_clk(clk), .rd_clk(clk), .rst(rst), .sync_mode(sync_mode),
        .load_n(load_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
        .wr_data(wr_data), .wr_count(wr_count), .rd_count(rd_count),
        .rd_data(rd_data), .ae_n(ae_n), .af_n(af_n), .push(push), .pop(pop)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit armed = 0;
    bit done = 0;

    // behavioural reference
    int m_e, m_f, m_rd;
    bit m_ws, m_rs, m_ae, m_af;

    always @(posedge clk) begin
        if (rst) begin
            m_e = OFS_DEFAULT; m_f = OFS_DEFAULT; m_rd = 0;
            m_ws = 0; m_rs = 0; m_ae = 0; m_af = 1;
            armed = 1;
        end else begin
            m_ae = !(int'(rd_count) <= m_e);
            m_af = !(int'(wr_count) + m_f >= DEPTH);
            if (!load_n && !rd_en_n) begin
                m_rd = m_rs ? m_f : m_e;
                m_rs = !m_rs;
            end
            if (!load_n && !wr_en_n) begin
                if (m_ws) m_f = int'(wr_data[OFS_W-1:0]);
                else      m_e = int'(wr_data[OFS_W-1:0]);
                m_ws = !m_ws;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            int e_ae, e_af;
            e_ae = sync_mode ? int'(m_ae) : int'(!(int'(rd_count) <= m_e));
            e_af = sync_mode ? int'(m_af) : int'(!(int'(wr_count) + m_f >= DEPTH));
            check("R4 rd_data", int'(rd_data), m_rd);
            check(sync_mode ? "R7/R5 ae_n" : "R8/R5 ae_n", int'(ae_n), e_ae);
            check(sync_mode ? "R7/R6 af_n" : "R8/R6 af_n", int'(af_n), e_af);
            check("R9 push", int'(push), int'(load_n && !wr_en_n));
            check("R9 pop", int'(pop), int'(load_n && !rd_en_n));
        end
    end

    task automatic step(input bit l, input bit w, input bit r, input int d,
                        input int wc, input int rc, input bit m);
        @(posedge clk);
        #1;
        load_n = l; wr_en_n = w; rd_en_n = r;
        wr_data = DATA_W'(d); wr_count = CNT_W'(wc); rd_count = CNT_W'(rc);
        sync_mode = m;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: defaults visible after reset
        step(1, 1, 1, 0, 0, 0, 1);
        step(1, 1, 1, 0, 0, 0, 1);
        // R4: read back defaults, empty then full
        step(0, 1, 0, 0, 0, 0, 1);
        step(0, 1, 0, 0, 0, 0, 1);
        step(1, 1, 1, 0, 0, 0, 1);
        // R2: alternating stores empty, full, empty
        step(0, 0, 1, 10, 0, 0, 1);
        step(0, 0, 1, 200, 0, 0, 1);
        step(0, 0, 1, 5, 0, 0, 1);
        // R3: leave load mode, then continue with the full threshold
        step(1, 1, 1, 0, 0, 0, 1);
        step(0, 0, 1, 300, 0, 0, 1);
        step(1, 1, 1, 0, 0, 0, 1);
        step(0, 1, 0, 0, 0, 0, 1);
        step(0, 1, 0, 0, 0, 0, 1);
        // R10 and R9: enables with load high act on the FIFO only
        step(1, 0, 0, 999, 0, 0, 1);
        step(1, 0, 1, 777, 0, 0, 1);
        step(1, 1, 1, 0, 0, 0, 1);
        step(0, 1, 0, 0, 0, 0, 1);
        step(0, 1, 0, 0, 0, 0, 1);
        step(1, 1, 1, 0, 0, 0, 1);
        // R5/R6/R7: clocked flags around thresholds 5 and 300
        step(1, 1, 1, 0, 16083, 5, 1);
        step(1, 1, 1, 0, 16084, 6, 1);
        step(1, 1, 1, 0, 16384, 7, 1);
        step(1, 1, 1, 0, 0, 5, 1);
        step(1, 1, 1, 0, 0, 0, 1);
        // R8: combinational flags
        step(1, 1, 1, 0, 16084, 5, 0);
        step(1, 1, 1, 0, 16083, 6, 0);
        step(1, 1, 1, 0, 16384, 0, 0);
        // R6: full threshold 0 only flags a completely full FIFO
        step(0, 0, 1, 0, 16383, 6, 0);
        step(0, 0, 1, 0, 16383, 6, 0);
        step(1, 1, 1, 0, 16384, 0, 0);
        step(1, 1, 1, 0, 16383, 0, 1);
        step(1, 1, 1, 0, 16383, 0, 1);
        // R1: reset again restores defaults
        step(1, 1, 1, 0, 16257, 127, 1);
        #1 rst = 1'b1;
        step(1, 1, 1, 0, 16257, 127, 1);
        #1 rst = 1'b0;
        step(0, 1, 0, 0, 16257, 127, 1);
        step(0, 1, 0, 0, 16256, 128, 1);
        step(1, 1, 1, 0, 16256, 128, 1);
        step(1, 1, 1, 0, 16256, 128, 1);
        @(negedge clk);
        @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule